// File: doc/BRIEF.md
# DMA Address Generator with Constant-Window Addressing

This block produces the per-beat source and destination addresses for one channel of a DMA transfer engine. A transfer is a grid of arrays, each made of a fixed number of elements. Software programs a base address for each side, an element count, an array count, a per-side stride between array starts, and an option word. For each side, the option word selects one of two addressing modes. In incrementing mode, the address walks linearly through memory. In constant mode, the address loops inside a small power-of-two window at the start of the current array, as a hardware FIFO register bank would need.

A start pulse loads all parameters. If a side is in constant mode, the block checks its alignment rules at that moment. If a rule is broken, the block reports an error with a cause code and issues no addresses. If the parameters are valid, the block presents one address pair per beat under a ready/valid handshake with the memory side. It signals completion with a single-cycle pulse.

Top module: `dma_addr_gen`

## Requirements
- R1: After reset, beat_valid, done and err are all low, and err_cause is 0.
- R2: On a start with valid parameters and non-zero counts, beat_valid is high in the next cycle, src_addr equals src_base, dst_addr equals dst_base, and err is low.
- R3: For a side in incrementing mode, each accepted beat within an array raises its address by ELEM_BYTES. The first beat of array k is at base plus k times that side's stride.
- R4: For a side in constant mode with width code c (0 to 5), the window is 2^c bytes. The address of beat e in array k is base + k*stride + ((e*ELEM_BYTES) mod window).
- R5: A beat is accepted only when beat_valid and beat_ready are both high. While beat_valid is high and beat_ready is low, both addresses hold their values.
- R6: In the cycle after the last beat of the last array is accepted, done is high for exactly one cycle and beat_valid is low. After that, the block is idle, and beat_ready has no effect.
- R7: In opt_word, bit 0 is the source mode and bit 1 is the destination mode, with 1 meaning constant and 0 meaning incrementing. Bits 10:8 hold the width code. All other bits are ignored.
- R8: A start with invalid parameters raises err in the next cycle and keeps beat_valid low. Causes: 4 means the width code is 6 or 7 while either side is constant. 1 means a constant source base whose bits 4:0 are not zero. 2 means the same for the destination base. 3 means a constant side whose stride has bits 4:0 not zero. When several apply, the priority order is 4, 1, 2, 3. err and err_cause hold until the next start.
- R9: When neither side is in constant mode, the width code and all alignment rules are not checked, and the transfer runs.
- R10: A valid start with an element count or array count of zero pulses done in the next cycle and issues no beats.
- R11: A start pulse while a transfer is issuing beats is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Load parameters and begin a transfer |
| opt_word | input | OPT_W | Mode bits and width code |
| src_base | input | ADDR_W | Source base address |
| dst_base | input | ADDR_W | Destination base address |
| elem_cnt | input | CNT_W | Elements per array |
| arr_cnt | input | CNT_W | Arrays per transfer |
| src_bidx | input | BIDX_W | Source stride between array starts (bytes) |
| dst_bidx | input | BIDX_W | Destination stride between array starts (bytes) |
| src_addr | output | ADDR_W | Current source address |
| dst_addr | output | ADDR_W | Current destination address |
| beat_valid | output | 1 | Address pair is valid |
| beat_ready | input | 1 | Memory side accepts the beat |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Parameter error held |
| err_cause | output | 3 | Error cause code |

## Verification
The checker watches several properties on every cycle: addresses hold while a beat is stalled, done lasts a single cycle and never overlaps a valid beat or an error, and an error keeps beat_valid low and holds its cause until the next start. The actual address values need the bench's scenarios to confirm: the linear walk, the wrap inside the constant window, the stride step between arrays, the error-cause priority, the zero-count case, and the ignored start pulse. The bench checks these against a reference model.

// File: rtl/dag_pkg.sv
package dag_pkg;

    typedef enum logic [2:0] {
        ERR_NONE      = 3'd0,
        ERR_SRC_ALIGN = 3'd1,
        ERR_DST_ALIGN = 3'd2,
        ERR_STRIDE    = 3'd3,
        ERR_WIDTH     = 3'd4
    } err_cause_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_DONE,
        ST_ERR
    } state_e;

    localparam int OPT_SRC_MODE_BIT = 0;
    localparam int OPT_DST_MODE_BIT = 1;
    localparam int OPT_FW_LSB       = 8;
    localparam int FW_CODE_W        = 3;
    localparam int FW_MAX_CODE      = 5;
    localparam int ALIGN_BYTES      = 32;
    localparam int ALIGN_LSB        = $clog2(ALIGN_BYTES);
    localparam int WIN_W            = ALIGN_LSB + 1;

    // Window size in bytes for a legal width code (1 to 32 bytes).
    function automatic logic [WIN_W-1:0] window_bytes(input logic [FW_CODE_W-1:0] code);
        return WIN_W'(1) << code;
    endfunction

endpackage

// File: rtl/dag_param_check.sv
module dag_param_check
    import dag_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int BIDX_W = 16
) (
    input  logic                 src_const,
    input  logic                 dst_const,
    input  logic [FW_CODE_W-1:0] fw_code,
    input  logic [ADDR_W-1:0]    src_base,
    input  logic [ADDR_W-1:0]    dst_base,
    input  logic [BIDX_W-1:0]    src_bidx,
    input  logic [BIDX_W-1:0]    dst_bidx,
    output err_cause_e           cause
);

    logic any_const;
    logic width_bad;
    logic src_mis;
    logic dst_mis;
    logic stride_bad;

    always_comb begin
        any_const  = src_const | dst_const;
        width_bad  = any_const && (fw_code > FW_CODE_W'(FW_MAX_CODE));
        src_mis    = src_const && (src_base[ALIGN_LSB-1:0] != '0);
        dst_mis    = dst_const && (dst_base[ALIGN_LSB-1:0] != '0);
        stride_bad = (src_const && (src_bidx[ALIGN_LSB-1:0] != '0))
                  || (dst_const && (dst_bidx[ALIGN_LSB-1:0] != '0));

        if (width_bad)       cause = ERR_WIDTH;
        else if (src_mis)    cause = ERR_SRC_ALIGN;
        else if (dst_mis)    cause = ERR_DST_ALIGN;
        else if (stride_bad) cause = ERR_STRIDE;
        else                 cause = ERR_NONE;
    end

endmodule

// File: rtl/dag_beat_cnt.sv
module dag_beat_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [CNT_W-1:0] elem_cnt,
    input  logic [CNT_W-1:0] arr_cnt,
    output logic             arr_end,
    output logic             xfer_end
);

    typedef struct packed {
        logic [CNT_W-1:0] e_idx;
        logic [CNT_W-1:0] a_idx;
        logic [CNT_W-1:0] e_cnt;
        logic [CNT_W-1:0] a_cnt;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    assign arr_end  = (cnt_q.e_idx == cnt_q.e_cnt - CNT_W'(1));
    assign xfer_end = arr_end && (cnt_q.a_idx == cnt_q.a_cnt - CNT_W'(1));

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d.e_idx = '0;
            cnt_d.a_idx = '0;
            cnt_d.e_cnt = elem_cnt;
            cnt_d.a_cnt = arr_cnt;
        end else if (step) begin
            if (arr_end) begin
                cnt_d.e_idx = '0;
                cnt_d.a_idx = cnt_q.a_idx + CNT_W'(1);
            end else begin
                cnt_d.e_idx = cnt_q.e_idx + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/dag_side_addr.sv
module dag_side_addr
    import dag_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int BIDX_W     = 16,
    parameter int ELEM_BYTES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [ADDR_W-1:0]    base,
    input  logic [BIDX_W-1:0]    bidx,
    input  logic                 const_mode,
    input  logic [FW_CODE_W-1:0] fw_code,
    input  logic                 step,
    input  logic                 arr_end,
    output logic [ADDR_W-1:0]    addr
);

    typedef struct packed {
        logic [ADDR_W-1:0] arr_start;
        logic [ADDR_W-1:0] off;
        logic [BIDX_W-1:0] bidx;
        logic              is_const;
        logic [WIN_W-1:0]  win;
    } side_t;

    side_t side_d, side_q;
    logic [ADDR_W-1:0] off_inc;

    assign addr = side_q.arr_start + side_q.off;

    always_comb begin
        side_d  = side_q;
        off_inc = side_q.off + ADDR_W'(ELEM_BYTES);
        if (load) begin
            side_d.arr_start = base;
            side_d.off       = '0;
            side_d.bidx      = bidx;
            side_d.is_const  = const_mode;
            side_d.win       = window_bytes(fw_code);
        end else if (step) begin
            if (arr_end) begin
                side_d.arr_start = side_q.arr_start + ADDR_W'(side_q.bidx);
                side_d.off       = '0;
            end else if (side_q.is_const) begin
                side_d.off = (off_inc >= ADDR_W'(side_q.win)) ? '0 : off_inc;
            end else begin
                side_d.off = off_inc;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) side_q <= '0;
        else        side_q <= side_d;
    end

endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
    import dag_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int CNT_W      = 8,
    parameter int BIDX_W     = 16,
    parameter int OPT_W      = 16,
    parameter int ELEM_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [OPT_W-1:0]  opt_word,
    input  logic [ADDR_W-1:0] src_base,
    input  logic [ADDR_W-1:0] dst_base,
    input  logic [CNT_W-1:0]  elem_cnt,
    input  logic [CNT_W-1:0]  arr_cnt,
    input  logic [BIDX_W-1:0] src_bidx,
    input  logic [BIDX_W-1:0] dst_bidx,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr,
    output logic              beat_valid,
    input  logic              beat_ready,
    output logic              done,
    output logic              err,
    output logic [2:0]        err_cause
);

    localparam int NUM_SIDES = 2;

    typedef struct packed {
        state_e     st;
        err_cause_e cause;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic                 src_const, dst_const;
    logic [FW_CODE_W-1:0] fw_code;
    err_cause_e           chk_cause;
    logic                 load, step;
    logic                 arr_end, xfer_end;
    logic                 zero_cnt;

    logic [ADDR_W-1:0] side_base [NUM_SIDES];
    logic [BIDX_W-1:0] side_bidx [NUM_SIDES];
    logic              side_cm   [NUM_SIDES];
    logic [ADDR_W-1:0] side_addr [NUM_SIDES];

    assign src_const = opt_word[OPT_SRC_MODE_BIT];
    assign dst_const = opt_word[OPT_DST_MODE_BIT];
    assign fw_code   = opt_word[OPT_FW_LSB +: FW_CODE_W];
    assign zero_cnt  = (elem_cnt == '0) || (arr_cnt == '0);

    assign side_base[0] = src_base;
    assign side_base[1] = dst_base;
    assign side_bidx[0] = src_bidx;
    assign side_bidx[1] = dst_bidx;
    assign side_cm[0]   = src_const;
    assign side_cm[1]   = dst_const;

    dag_param_check #(
        .ADDR_W (ADDR_W),
        .BIDX_W (BIDX_W)
    ) u_check (
        .src_const (src_const),
        .dst_const (dst_const),
        .fw_code   (fw_code),
        .src_base  (src_base),
        .dst_base  (dst_base),
        .src_bidx  (src_bidx),
        .dst_bidx  (dst_bidx),
        .cause     (chk_cause)
    );

    dag_beat_cnt #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .step     (step),
        .elem_cnt (elem_cnt),
        .arr_cnt  (arr_cnt),
        .arr_end  (arr_end),
        .xfer_end (xfer_end)
    );

    for (genvar g = 0; g < NUM_SIDES; g++) begin : g_side
        dag_side_addr #(
            .ADDR_W     (ADDR_W),
            .BIDX_W     (BIDX_W),
            .ELEM_BYTES (ELEM_BYTES)
        ) u_side (
            .clk        (clk),
            .rst_n      (rst_n),
            .load       (load),
            .base       (side_base[g]),
            .bidx       (side_bidx[g]),
            .const_mode (side_cm[g]),
            .fw_code    (fw_code),
            .step       (step),
            .arr_end    (arr_end),
            .addr       (side_addr[g])
        );
    end

    assign src_addr = side_addr[0];
    assign dst_addr = side_addr[1];

    always_comb begin
        ctl_d = ctl_q;
        load  = 1'b0;
        step  = 1'b0;
        if (ctl_q.st == ST_RUN) begin
            step = beat_ready;
            if (beat_ready && xfer_end) ctl_d.st = ST_DONE;
        end else begin
            if (ctl_q.st == ST_DONE) ctl_d.st = ST_IDLE;
            if (start) begin
                load = 1'b1;
                if (chk_cause != ERR_NONE) begin
                    ctl_d.st    = ST_ERR;
                    ctl_d.cause = chk_cause;
                end else begin
                    ctl_d.cause = ERR_NONE;
                    ctl_d.st    = zero_cnt ? ST_DONE : ST_RUN;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.st    <= ST_IDLE;
            ctl_q.cause <= ERR_NONE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign beat_valid = (ctl_q.st == ST_RUN);
    assign done       = (ctl_q.st == ST_DONE);
    assign err        = (ctl_q.st == ST_ERR);
    assign err_cause  = ctl_q.cause;

endmodule

// File: rtl/dag_checker.sv
module dag_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              beat_valid,
    input logic              beat_ready,
    input logic [ADDR_W-1:0] src_addr,
    input logic [ADDR_W-1:0] dst_addr,
    input logic              done,
    input logic              err,
    input logic [2:0]        err_cause
);

    p_hold_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid && !beat_ready |=> beat_valid && $stable(src_addr) && $stable(dst_addr));

    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_alone_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !beat_valid && !err);

    p_err_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !beat_valid && (err_cause != 3'd0));

    p_err_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err && !start |=> err && $stable(err_cause));

    p_stall_no_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid && !beat_ready && start |=> beat_valid);

endmodule

bind dma_addr_gen dag_checker #(.ADDR_W(ADDR_W)) u_dag_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .beat_valid (beat_valid),
    .beat_ready (beat_ready),
    .src_addr   (src_addr),
    .dst_addr   (dst_addr),
    .done       (done),
    .err        (err),
    .err_cause  (err_cause)
);

// File: tb/dma_addr_gen_tb_top.sv
module dma_addr_gen_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int EB         = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] opt_word = '0;
    logic [31:0] src_base = '0, dst_base = '0;
    logic [7:0]  elem_cnt = '0, arr_cnt = '0;
    logic [15:0] src_bidx = '0, dst_bidx = '0;
    logic [31:0] src_addr, dst_addr;
    logic        beat_valid, beat_ready = 1'b0, done, err;
    logic [2:0]  err_cause;

    int nchk  = 0;
    int nfail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_addr_gen dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .opt_word(opt_word),
        .src_base(src_base), .dst_base(dst_base), .elem_cnt(elem_cnt), .arr_cnt(arr_cnt),
        .src_bidx(src_bidx), .dst_bidx(dst_bidx), .src_addr(src_addr), .dst_addr(dst_addr),
        .beat_valid(beat_valid), .beat_ready(beat_ready), .done(done), .err(err),
        .err_cause(err_cause)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] model_addr(input logic [31:0] base, input logic [15:0] bidx,
                                               input bit cm, input logic [2:0] code,
                                               input int a, input int e);
        logic [31:0] off;
        off = 32'(e * EB);
        if (cm) off = off % (32'd1 << code);
        return base + 32'(a) * 32'(bidx) + off;
    endfunction

    function automatic int model_cause(input logic [15:0] opt, input logic [31:0] sb, input logic [31:0] db,
                                       input logic [15:0] sx, input logic [15:0] dx);
        bit sc = opt[0];
        bit dc = opt[1];
        if ((sc || dc) && opt[10:8] > 3'd5) return 4;
        if (sc && sb[4:0] != 5'd0) return 1;
        if (dc && db[4:0] != 5'd0) return 2;
        if ((sc && sx[4:0] != 5'd0) || (dc && dx[4:0] != 5'd0)) return 3;
        return 0;
    endfunction

    task automatic run_xfer(input logic [15:0] opt, input logic [31:0] sb, input logic [31:0] db,
                            input logic [7:0] ec, input logic [7:0] ac,
                            input logic [15:0] sx, input logic [15:0] dx, input bit poke);
        int ec_exp;
        bit rdy;
        ec_exp = model_cause(opt, sb, db, sx, dx);
        @(negedge clk);
        opt_word = opt; src_base = sb; dst_base = db;
        elem_cnt = ec; arr_cnt = ac; src_bidx = sx; dst_bidx = dx;
        beat_ready = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (ec_exp != 0) begin
            check(err && err_cause == 3'(ec_exp), "R8 cause", {err, err_cause}, {1'b1, 3'(ec_exp)});
            check(!beat_valid, "R8 no valid", beat_valid, 0);
            beat_ready = 1'b1;
            repeat (2) @(negedge clk);
            check(err && err_cause == 3'(ec_exp) && !beat_valid, "R8 hold", {err, err_cause}, {1'b1, 3'(ec_exp)});
            beat_ready = 1'b0;
            return;
        end
        check(!err, "R8 cleared on good start", err, 0);
        if (ec == 0 || ac == 0) begin
            check(done && !beat_valid, "R10 done", {done, beat_valid}, 2'b10);
            @(negedge clk);
            check(!done && !beat_valid, "R10 idle", {done, beat_valid}, 2'b00);
            return;
        end
        check(beat_valid && src_addr == sb && dst_addr == db, "R2 first", {src_addr, dst_addr}, {sb, db});
        for (int a = 0; a < int'(ac); a++) begin
            for (int e = 0; e < int'(ec); e++) begin
                logic [31:0] es, ed;
                es = model_addr(sb, sx, opt[0], opt[10:8], a, e);
                ed = model_addr(db, dx, opt[1], opt[10:8], a, e);
                do begin
                    check(beat_valid, "R5 valid held", beat_valid, 1);
                    check(src_addr == es, opt[0] ? "R4 src" : "R3 src", src_addr, es);
                    check(dst_addr == ed, opt[1] ? "R4 dst" : "R3 dst", dst_addr, ed);
                    rdy = ($urandom % 4) != 0;
                    if (poke && a == 0 && e == 1) begin
                        src_base = ~sb; start = 1'b1;
                    end
                    beat_ready = rdy;
                    @(negedge clk);
                    if (start) begin
                        start = 1'b0; src_base = sb;
                        check(beat_valid, "R11 start ignored", beat_valid, 1);
                    end
                end while (!rdy);
            end
        end
        check(done && !beat_valid, "R6 done pulse", {done, beat_valid}, 2'b10);
        beat_ready = 1'b1;
        @(negedge clk);
        check(!done && !beat_valid, "R6 single", {done, beat_valid}, 2'b00);
        @(negedge clk);
        check(!done && !beat_valid, "R6 ready ignored", {done, beat_valid}, 2'b00);
        beat_ready = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        nfail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        void'($urandom(32'd7351));
        repeat (3) @(negedge clk);
        check(!beat_valid && !done && !err && err_cause == 0, "R1 reset", {beat_valid, done, err, err_cause}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!beat_valid && !done && !err, "R1 after release", {beat_valid, done, err}, 0);

        // R3 both sides incrementing
        run_xfer(16'h0000, 32'h0000_1000, 32'h0000_8000, 8'd4, 8'd3, 16'h0040, 16'h0100, 1'b0);
        // R4 source constant, 8-byte window
        run_xfer(16'h0301, 32'h0000_2000, 32'h0000_9004, 8'd5, 8'd2, 16'h0020, 16'h0014, 1'b0);
        // R4 destination constant, 32-byte window
        run_xfer(16'h0502, 32'h0000_3003, 32'h0001_0000, 8'd10, 8'd2, 16'h0008, 16'h0040, 1'b0);
        // R4 window smaller than element, both constant
        run_xfer(16'h0003, 32'h0000_4000, 32'h0000_5000, 8'd3, 8'd2, 16'h0020, 16'h0060, 1'b0);
        // R7 stray option bits ignored
        run_xfer(16'hF2FD, 32'h0000_6000, 32'h0000_7000, 8'd6, 8'd2, 16'h0020, 16'h0010, 1'b0);
        // R8 each cause and priority
        run_xfer(16'h0201, 32'h0000_1004, 32'h0000_2000, 8'd2, 8'd1, 16'h0020, 16'h0000, 1'b0);
        run_xfer(16'h0202, 32'h0000_1000, 32'h0000_2010, 8'd2, 8'd1, 16'h0000, 16'h0020, 1'b0);
        run_xfer(16'h0201, 32'h0000_1000, 32'h0000_2000, 8'd2, 8'd1, 16'h0010, 16'h0000, 1'b0);
        run_xfer(16'h0602, 32'h0000_1000, 32'h0000_2001, 8'd2, 8'd1, 16'h0003, 16'h0005, 1'b0);
        run_xfer(16'h0703, 32'h0000_1001, 32'h0000_2000, 8'd2, 8'd1, 16'h0000, 16'h0000, 1'b0);
        // R9 no constant side: reserved width and misalignment pass
        run_xfer(16'h0700, 32'h0000_1003, 32'h0000_2005, 8'd3, 8'd2, 16'h0011, 16'h0007, 1'b0);
        // R10 zero counts
        run_xfer(16'h0000, 32'h0000_1000, 32'h0000_2000, 8'd0, 8'd3, 16'h0000, 16'h0000, 1'b0);
        run_xfer(16'h0301, 32'h0000_1000, 32'h0000_2000, 8'd2, 8'd0, 16'h0020, 16'h0000, 1'b0);
        // R11 start pulse mid-transfer
        run_xfer(16'h0000, 32'h0000_A000, 32'h0000_B000, 8'd4, 8'd2, 16'h0080, 16'h0080, 1'b1);

        for (int i = 0; i < 40; i++) begin
            logic [15:0] opt;
            logic [31:0] sb, db;
            logic [15:0] sx, dx;
            opt = {5'd0, 3'($urandom % 8), 6'd0, 2'($urandom % 4)};
            if (($urandom % 4) != 0) opt[10:8] = 3'($urandom % 6);
            sb = {16'd0, 16'($urandom)};
            db = {16'd0, 16'($urandom)};
            sx = 16'($urandom % 8) * 16'd32;
            dx = 16'($urandom % 8) * 16'd32;
            if (($urandom % 4) != 0) begin sb[4:0] = '0; db[4:0] = '0; end
            if (($urandom % 6) == 0) sx[2:0] = 3'($urandom);
            run_xfer(opt, sb, db, 8'(1 + $urandom % 9), 8'(1 + $urandom % 3), sx, dx, 1'b0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule